// File: doc/BRIEF.md
# Power-Good Window Qualifier

This block produces the power-good flag of a point-of-load regulator from two digital comparator outputs that watch the divided-down feedback node. One comparator reports that the feedback sits above the lower bound, near 90% of the 1.000 V reference. The other reports that it sits below the upper bound, near 110.5% of the reference. Both comparators carry their own hysteresis in the analog domain. The feedback counts as in the window only when both comparators agree. Their outputs are asynchronous to the logic clock, so each one passes through a flop synchronizer first.

The flag changes state only after the feedback has held its new condition for a full qualification run of reference-clock ticks. The run is 64 ticks by default and is the same in both directions. A tick is a one-cycle enable that marks each reference-clock period. If the condition reverses during a run, the run is abandoned and its count is discarded. Shutdown and undervoltage lockout each force the flag low at once and send the qualifier back to its not-good state. Besides the active-high flag, the block drives the enable of an open-drain pull-down. That enable is active whenever the flag is low, so the flag can be wired to the enable input of the next regulator in a power-up chain.

The controller has four states:
- `PG_LOW`: not good, no run in progress.
- `PG_QUAL_IN`: not good, qualifying an entry into the window.
- `PG_HIGH`: good, no run in progress.
- `PG_QUAL_OUT`: good, qualifying an exit from the window.

It has these transitions:
- *enter*: `PG_LOW`→`PG_QUAL_IN`.
- *abort-in*: `PG_QUAL_IN`→`PG_LOW`.
- *grant*: `PG_QUAL_IN`→`PG_HIGH`.
- *leave*: `PG_HIGH`→`PG_QUAL_OUT`.
- *abort-out*: `PG_QUAL_OUT`→`PG_HIGH`.
- *revoke*: `PG_QUAL_OUT`→`PG_LOW`.
- *kill*: any state→`PG_LOW`.

Top module: `pgood_qualifier`

## Requirements
- R1: While reset is asserted and right after it is released, `pgood_o` is 0 and `pgood_pull_en_o` is 1.
- R2: The feedback is in the window only when `fb_above_lo_i` and `fb_below_hi_i` are both 1. Each input passes through SYNC_STAGES flops (default 2) before the controller sees it. The controller takes the enter transition on the clock edge after the synchronized window signal becomes 1.
- R3: In `PG_QUAL_IN`, each clock edge with `ref_tick_i`=1 counts one tick. The edge that counts the QUAL_TICKS-th tick (default 64) sets `pgood_o` to 1. With a tick on every cycle, `pgood_o` rises 67 clock edges after a steady in-window input is applied.
- R4: If the window condition drops during an entry run, the run is discarded and `pgood_o` stays 0. The next entry needs a complete new run.
- R5: In `PG_QUAL_OUT`, the edge that counts the QUAL_TICKS-th out-of-window tick clears `pgood_o`. With a tick on every cycle, `pgood_o` falls 67 clock edges after a steady out-of-window input is applied.
- R6: If the feedback returns to the window during an exit run, `pgood_o` stays 1 and the exit count is discarded. A later exit needs a complete new run.
- R7: Clock edges without `ref_tick_i` never advance a run. If no ticks arrive, `pgood_o` does not change for any length of time in or out of the window.
- R8: `pgood_o` is 0 in the same cycle in which `shutdown_i` or `uvlo_i` is 1, and the controller returns to `PG_LOW`. After release with the feedback already in the window, and with a tick on every cycle, `pgood_o` rises 65 edges later.
- R9: `pgood_pull_en_o` is always the complement of `pgood_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle enable marking each reference-clock period |
| shutdown_i | input | 1 | Regulator shut down (active high) |
| uvlo_i | input | 1 | Input supply below lockout threshold (active high) |
| fb_above_lo_i | input | 1 | Comparator: feedback above the lower window bound (asynchronous) |
| fb_below_hi_i | input | 1 | Comparator: feedback below the upper window bound (asynchronous) |
| pgood_o | output | 1 | Power-good flag, active high |
| pgood_pull_en_o | output | 1 | Enable for the open-drain pull-down, active when not good |

## Verification
A controller stuck in the wrong state, or a run counter that is not cleared on a reversal, shows up at the ports as a flag edge at the wrong time. The flag either moves earlier than 67 edges after a clean window change, or it moves after an aborted run when it should not have moved at all. A counter that leaks across an abort is exposed within one run length, because the bench holds the new condition for exactly one edge less than a full run and then checks that the flag has not moved. A missed kill path shows in the same cycle, because the flag must drop combinationally. A missed return to `PG_LOW` shows 65 edges after release, when the requalification must take a full run.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

    typedef enum logic [1:0] {
        PG_LOW      = 2'd0,
        PG_QUAL_IN  = 2'd1,
        PG_HIGH     = 2'd2,
        PG_QUAL_OUT = 2'd3
    } pg_state_e;

    function automatic logic pg_is_good(input pg_state_e s);
        return (s == PG_HIGH) || (s == PG_QUAL_OUT);
    endfunction

    function automatic logic pg_is_qualifying(input pg_state_e s);
        return (s == PG_QUAL_IN) || (s == PG_QUAL_OUT);
    endfunction

endpackage

// File: rtl/pgood_sync.sv
module pgood_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) begin
                        stage_q[s] <= async_i;
                    end else begin
                        stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pgood_tick_counter.sv
module pgood_tick_counter #(
    parameter int QUAL_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic advance_i,
    output logic last_o
);
    localparam int CW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (advance_i && (count_q != LAST)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last_o = (count_q == LAST);
endmodule

// File: rtl/pgood_fsm.sv
module pgood_fsm
    import pgood_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_i,
    input  logic tick_i,
    input  logic kill_i,
    input  logic last_i,
    output logic cnt_clear_o,
    output logic cnt_adv_o,
    output logic good_o
);
    pg_state_e state_q, state_nx;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PG_LOW: begin
                if (win_i) state_nx = PG_QUAL_IN;                   // enter
            end
            PG_QUAL_IN: begin
                if (!win_i)                state_nx = PG_LOW;        // abort-in
                else if (tick_i && last_i) state_nx = PG_HIGH;       // grant
            end
            PG_HIGH: begin
                if (!win_i) state_nx = PG_QUAL_OUT;                  // leave
            end
            PG_QUAL_OUT: begin
                if (win_i)                 state_nx = PG_HIGH;       // abort-out
                else if (tick_i && last_i) state_nx = PG_LOW;        // revoke
            end
            default: state_nx = PG_LOW;
        endcase
        if (kill_i) state_nx = PG_LOW;                               // kill
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_LOW;
        else        state_q <= state_nx;
    end

    // outputs
    always_comb begin
        cnt_adv_o   = tick_i && pg_is_qualifying(state_q) && (state_nx == state_q);
        cnt_clear_o = (state_nx != state_q) || !pg_is_qualifying(state_q);
        good_o      = pg_is_good(state_q) && !kill_i;
    end
endmodule

// File: rtl/pgood_qualifier.sv
module pgood_qualifier #(
    parameter int QUAL_TICKS  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic shutdown_i,
    input  logic uvlo_i,
    input  logic fb_above_lo_i,
    input  logic fb_below_hi_i,
    output logic pgood_o,
    output logic pgood_pull_en_o
);
    logic [1:0] cmp_sync;
    logic       win_sync;
    logic       kill;
    logic       cnt_clear, cnt_adv, cnt_last;
    logic       good;

    pgood_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fb_above_lo_i, fb_below_hi_i}),
        .sync_o  (cmp_sync)
    );

    assign win_sync = &cmp_sync;
    assign kill     = shutdown_i | uvlo_i;

    pgood_tick_counter #(.QUAL_TICKS(QUAL_TICKS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (cnt_clear),
        .advance_i (cnt_adv),
        .last_o    (cnt_last)
    );

    pgood_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_i       (win_sync),
        .tick_i      (ref_tick_i),
        .kill_i      (kill),
        .last_i      (cnt_last),
        .cnt_clear_o (cnt_clear),
        .cnt_adv_o   (cnt_adv),
        .good_o      (good)
    );

    assign pgood_o         = good;
    assign pgood_pull_en_o = ~good;
endmodule

// File: rtl/pgood_qualifier_chk.sv
module pgood_qualifier_chk #(
    parameter int QUAL_TICKS = 64
) (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic kill,
    input logic win_sync,
    input logic pgood
);
    localparam int RW = $clog2(QUAL_TICKS + 1) + 1;
    localparam logic [RW-1:0] FULL = RW'(QUAL_TICKS);

    logic [RW-1:0] in_run, out_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_run  <= '0;
            out_run <= '0;
        end else begin
            if (!win_sync || kill)            in_run <= '0;
            else if (ref_tick && in_run != FULL) in_run <= in_run + 1'b1;
            if (win_sync || kill)             out_run <= '0;
            else if (ref_tick && out_run != FULL) out_run <= out_run + 1'b1;
        end
    end

    // R8
    kill_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !pgood);

    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(ref_tick));

    // R3
    rise_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> (in_run >= FULL));

    // R5
    fall_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pgood) && !kill && !$past(kill)) |-> ((out_run >= FULL) && $past(ref_tick)));

    // R7
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ref_tick) && !kill && !$past(kill)) |-> $stable(pgood));
endmodule

bind pgood_qualifier pgood_qualifier_chk #(.QUAL_TICKS(QUAL_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick_i),
    .kill     (kill),
    .win_sync (win_sync),
    .pgood    (pgood_o)
);

// File: tb/pgood_qualifier_tb.sv
module pgood_qualifier_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic sd = 1'b0, uv = 1'b0, alo = 1'b0, bhi = 1'b0;
    logic pgood, pull_en;

    logic [1:0] tick_mode = 2'd0;   // 0 every cycle, 1 never, 2 every fourth
    int   phase = 0;
    int   n_checks = 0, n_fails = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        phase <= (phase + 1) % 4;
        case (tick_mode)
            2'd0:    ref_tick <= 1'b1;
            2'd1:    ref_tick <= 1'b0;
            default: ref_tick <= (phase == 0);
        endcase
    end

    pgood_qualifier dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .ref_tick_i      (ref_tick),
        .shutdown_i      (sd),
        .uvlo_i          (uv),
        .fb_above_lo_i   (alo),
        .fb_below_hi_i   (bhi),
        .pgood_o         (pgood),
        .pgood_pull_en_o (pull_en)
    );

    typedef struct packed {
        logic alo;
        logic bhi;
        logic sd;
        logic uv;
        int   hold;
        logic exp;
        int   req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 66, 1'b0, 3},  // R3 one edge short
        '{1'b1, 1'b1, 1'b0, 1'b0,  1, 1'b1, 3},  // R3 grant at edge 67
        '{1'b0, 1'b1, 1'b0, 1'b0, 30, 1'b1, 5},  // R5 exit run partway
        '{1'b1, 1'b1, 1'b0, 1'b0,  5, 1'b1, 6},  // R6 re-entry aborts exit
        '{1'b1, 1'b0, 1'b0, 1'b0, 66, 1'b1, 6},  // R6 fresh exit run, short by one
        '{1'b1, 1'b0, 1'b0, 1'b0,  1, 1'b0, 5},  // R5 revoke at edge 67
        '{1'b1, 1'b1, 1'b0, 1'b0, 40, 1'b0, 4},  // R4 entry run partway
        '{1'b0, 1'b1, 1'b0, 1'b0,  3, 1'b0, 4},  // R4 abort-in
        '{1'b1, 1'b1, 1'b0, 1'b0, 66, 1'b0, 4},  // R4 fresh run, short by one
        '{1'b1, 1'b1, 1'b0, 1'b0,  1, 1'b1, 4},  // R4 grant after full run
        '{1'b1, 1'b1, 1'b1, 1'b0,  0, 1'b0, 8},  // R8 shutdown drops at once
        '{1'b1, 1'b1, 1'b1, 1'b0, 10, 1'b0, 8},  // R8 held low
        '{1'b1, 1'b1, 1'b0, 1'b0,  1, 1'b0, 8},  // R8 release, requalify
        '{1'b1, 1'b1, 1'b0, 1'b0, 63, 1'b0, 8},  // R8 short by one
        '{1'b1, 1'b1, 1'b0, 1'b0,  1, 1'b1, 8},  // R8 grant at edge 65
        '{1'b1, 1'b1, 1'b0, 1'b1,  0, 1'b0, 8},  // R8 lockout drops at once
        '{1'b1, 1'b1, 1'b0, 1'b1,  5, 1'b0, 8},  // R8 held low
        '{1'b0, 1'b0, 1'b0, 1'b0, 80, 1'b0, 2}   // R2 both comparators out
    };

    task automatic check(input logic exp, input string req, input string what);
        n_checks++;
        if (pgood !== exp || pull_en !== ~exp) begin
            n_fails++;
            $display("FAIL %s %s: pgood/pull_en actual %b/%b expected %b/%b",
                     req, what, pgood, pull_en, exp, ~exp);
        end
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            repeat (n) @(posedge clk);
            @(negedge clk);
        end else begin
            #1;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(1'b0, "R1", "during reset");
        rst_n = 1'b1;
        run(2);
        check(1'b0, "R1", "after reset");

        // vector walk, tick on every cycle
        for (int i = 0; i < NV; i++) begin
            alo = VEC[i].alo; bhi = VEC[i].bhi; sd = VEC[i].sd; uv = VEC[i].uv;
            run(VEC[i].hold);
            check(VEC[i].exp, $sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i));
        end
        uv = 1'b0;
        run(3);

        // R2 only one comparator satisfied
        alo = 1'b1; bhi = 1'b0;
        run(100);
        check(1'b0, "R2", "above low only");
        alo = 1'b0; bhi = 1'b1;
        run(100);
        check(1'b0, "R2", "below high only");

        // R7 no ticks: no run advances
        tick_mode = 2'd1;
        run(3);
        alo = 1'b1; bhi = 1'b1;
        run(300);
        check(1'b0, "R7", "in window, no ticks");

        // R7 slow ticks: one every fourth cycle
        tick_mode = 2'd2;
        run(250);
        check(1'b0, "R7", "slow ticks, fewer than a run");
        run(10);
        check(1'b1, "R7", "slow ticks, full run");
        alo = 1'b0;
        run(250);
        check(1'b1, "R7", "slow ticks exit, fewer than a run");
        run(10);
        check(1'b0, "R7", "slow ticks exit, full run");

        // R9 and R1 reset while good
        tick_mode = 2'd0;
        alo = 1'b1;
        run(70);
        check(1'b1, "R9", "good with pull-down off");
        rst_n = 1'b0;
        #1;
        check(1'b0, "R1", "reset while good");
        run(2);
        rst_n = 1'b1;
        run(1);
        check(1'b0, "R1", "after second reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule